// File: doc/BRIEF.md
# Configuration Register Commit Controller

This block holds a byte-addressed bank of configuration registers and copies it to an external non-volatile store. A serial-bus front end, which is not part of this block, issues single-byte writes and reads. Writing a 1 into the commit trigger bit, when it was 0 before, starts a copy of every register byte to the store. The copy goes one byte per handshake, from the lowest address upwards. While the copy runs the block reports busy, drops bus writes and records that it dropped them, and it still answers reads.

After reset the block first loads the live registers from the store. It uses the same handshake with the write strobe low, and it stays busy until the last byte has arrived. A lock bit takes effect only once it has been written to the store. From then on a trigger edge is ignored, but bus writes still change the live registers. The power-down bit and the trigger bit are always cleared in the image written to the store.

The sequencer has three states. ST_BOOT is entered at reset and moves to ST_IDLE when the last byte of the load is acknowledged. ST_IDLE moves to ST_SAVE on a trigger rising edge when the stored lock is clear. ST_SAVE returns to ST_IDLE when the last byte of the copy is acknowledged.

Top module: `cfg_commit_ctrl`

Register layout (addresses 0x00 to 0x4F; bit 7 is the MSB):

| Offset | Content |
|---|---|
| 0x00 | identity, read-only: bit 7 device type (1), bits 6:4 revision (2), bits 3:0 vendor (1), so it reads 0xA1 |
| 0x01 | bit 7 reserved (0), bit 6 busy (read-only), bit 5 lock, bit 4 power-down, bits 3:0 free |
| 0x06 | bits 7:1 block-read byte count (reset 0x50), bit 0 commit trigger |
| 0x07 | bit 0 write-reject flag (sticky, cleared by reading 0x07), bits 7:1 reserved |
| 0x08-0x0F | reserved |
| others | free configuration bytes |

## Requirements
- R1: After reset, busy is 1 and the block reads all 0x50 bytes from the store, in ascending address order. Busy falls after the last byte, and the live registers then hold the stored values.
- R2: Offset 0x00 always reads 0xA1, and bus writes to it have no effect.
- R3: These always read 0 and ignore writes: offset 0x01 bit 7, offsets 0x08-0x0F, bits 7:1 of offset 0x07, and any address of 0x50 or above.
- R4: The 7-bit byte count sits in offset 0x06 bits 7:1, resets to 0x50, and drives the blk_cnt port.
- R5: A commit starts only when offset 0x06 bit 0 goes from 0 to 1. Writing 1 again while it is already 1 starts nothing.
- R6: During a commit, the busy port and offset 0x01 bit 6 read 1, and exactly 0x50 store writes are issued in ascending order. Busy returns to 0 afterwards.
- R7: Bus writes during busy are dropped and set the reject flag (offset 0x07 bit 0). One read of 0x07 returns the flag and clears it. Reads are answered during busy.
- R8: Offset 0x01 bit 4 drives the pwr_down port live, but it is always written to the store as 0.
- R9: Setting the lock (offset 0x01 bit 5) only in the live register does not block a commit. Once it has been stored, trigger edges are ignored and busy stays 0, while bus writes still update live registers.
- R10: The trigger bit is always written to the store as 0.
- R11: A read returns its data on bus_rdata, with bus_rvalid high, in the cycle after bus_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_wr | input | 1 | byte write strobe |
| bus_rd | input | 1 | byte read strobe |
| bus_addr | input | 7 | register address |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data, registered |
| bus_rvalid | output | 1 | read data valid |
| busy | output | 1 | load or commit in progress |
| blk_cnt | output | 7 | block-read byte count |
| pwr_down | output | 1 | live power-down control |
| nv_req | output | 1 | store access request |
| nv_we | output | 1 | 1 write, 0 read |
| nv_addr | output | 7 | store byte address |
| nv_wdata | output | 8 | store write data |
| nv_rdata | input | 8 | store read data, valid with nv_ack |
| nv_ack | input | 1 | one-cycle completion of the current access |

## Verification
Several faults show up at the ports. A sequencer stuck in or wrongly leaving ST_SAVE shows as busy staying high or as a store-write count other than 0x50. A missed or repeated trigger-edge detection shows as busy rising within two cycles of a repeated trigger write, or not rising after a real 0-to-1 write. A wrongly held lock shows as busy never rising, or as a commit running after the lock was stored. Image masking faults appear in the store contents as soon as the copy ends, and reject-flag faults appear on the first read of offset 0x07.

// File: rtl/cfgc_pkg.sv
package cfgc_pkg;

    localparam int CFG_AW = 7;
    localparam int CFG_DW = 8;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_IDLE = 2'd1,
        ST_SAVE = 2'd2
    } seq_state_e;

    localparam logic [CFG_AW-1:0] OFS_ID   = 7'h00;
    localparam logic [CFG_AW-1:0] OFS_CTRL = 7'h01;
    localparam logic [CFG_AW-1:0] OFS_CNT  = 7'h06;
    localparam logic [CFG_AW-1:0] OFS_STAT = 7'h07;
    localparam logic [CFG_AW-1:0] RSV_LO   = 7'h08;
    localparam logic [CFG_AW-1:0] RSV_HI   = 7'h0F;

    localparam int BUSY_BIT = 6;
    localparam int LOCK_BIT = 5;
    localparam int PD_BIT   = 4;
    localparam int TRIG_BIT = 0;

    localparam logic [CFG_DW-1:0] CNT_RST = 8'hA0;

    // Bits a bus write or a load may change in the live bank.
    function automatic logic [CFG_DW-1:0] live_mask(input logic [CFG_AW-1:0] a);
        if (a == OFS_ID || a == OFS_STAT || (a >= RSV_LO && a <= RSV_HI))
            return 8'h00;
        else if (a == OFS_CTRL)
            return 8'h3F;
        else
            return 8'hFF;
    endfunction

    // Bits allowed to be 1 in the stored image.
    function automatic logic [CFG_DW-1:0] image_mask(input logic [CFG_AW-1:0] a);
        logic [CFG_DW-1:0] m;
        m = live_mask(a);
        if (a == OFS_CTRL) m[PD_BIT]   = 1'b0;
        if (a == OFS_CNT)  m[TRIG_BIT] = 1'b0;
        return m;
    endfunction

endpackage

// File: rtl/cfgc_regfile.sv
module cfgc_regfile
    import cfgc_pkg::*;
#(
    parameter int NUM_BYTES = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_AW-1:0] waddr,
    input  logic [CFG_DW-1:0] wdata,
    input  logic [CFG_AW-1:0] raddr_a,
    output logic [CFG_DW-1:0] rdata_a,
    input  logic [CFG_AW-1:0] raddr_b,
    output logic [CFG_DW-1:0] rdata_b,
    output logic              pd_bit,
    output logic              trig_bit,
    output logic [6:0]        cnt_field
);

    logic [CFG_DW-1:0] regs [NUM_BYTES];

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        localparam logic [CFG_DW-1:0] MASK  = live_mask(CFG_AW'(g));
        localparam logic [CFG_DW-1:0] RST_V = (g == int'(OFS_CNT)) ? CNT_RST : 8'h00;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= RST_V;
            else if (we && waddr == CFG_AW'(g))
                regs[g] <= (regs[g] & ~MASK) | (wdata & MASK);
        end
    end

    always_comb begin
        rdata_a = (int'(raddr_a) < NUM_BYTES) ? regs[raddr_a] : '0;
        rdata_b = (int'(raddr_b) < NUM_BYTES) ? regs[raddr_b] : '0;
    end

    assign pd_bit    = regs[OFS_CTRL][PD_BIT];
    assign trig_bit  = regs[OFS_CNT][TRIG_BIT];
    assign cnt_field = regs[OFS_CNT][7:1];

endmodule

// File: rtl/cfgc_seq.sv
module cfgc_seq
    import cfgc_pkg::*;
#(
    parameter int NUM_BYTES = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_bit,
    input  logic [CFG_DW-1:0] save_data,
    output logic              nv_req,
    output logic              nv_we,
    output logic [CFG_AW-1:0] nv_addr,
    output logic [CFG_DW-1:0] nv_wdata,
    input  logic [CFG_DW-1:0] nv_rdata,
    input  logic              nv_ack,
    output logic              ld_we,
    output logic [CFG_AW-1:0] ld_addr,
    output logic [CFG_DW-1:0] ld_data,
    output logic              busy,
    output logic              trig_rise,
    output logic              lock_st
);

    localparam logic [CFG_AW-1:0] LAST_IDX = CFG_AW'(NUM_BYTES - 1);

    seq_state_e        st, st_nxt;
    logic [CFG_AW-1:0] idx, idx_nxt;
    logic              trig_q;
    logic              last;

    assign last      = (idx == LAST_IDX);
    assign trig_rise = trig_bit & ~trig_q;

    // State register and tracked flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_BOOT;
            idx     <= '0;
            trig_q  <= 1'b0;
            lock_st <= 1'b0;
        end else begin
            st     <= st_nxt;
            idx    <= idx_nxt;
            trig_q <= trig_bit;
            if (nv_ack && idx == OFS_CTRL) begin
                if (st == ST_BOOT)
                    lock_st <= nv_rdata[LOCK_BIT];
                else if (st == ST_SAVE)
                    lock_st <= nv_wdata[LOCK_BIT];
            end
        end
    end

    // Next state and outputs
    always_comb begin
        st_nxt  = st;
        idx_nxt = idx;
        nv_req  = 1'b0;
        nv_we   = 1'b0;
        ld_we   = 1'b0;
        unique case (st)
            ST_BOOT: begin
                nv_req = 1'b1;
                if (nv_ack) begin
                    ld_we = 1'b1;
                    if (last) st_nxt = ST_IDLE;
                    else      idx_nxt = idx + 1'b1;
                end
            end
            ST_IDLE: begin
                if (trig_rise && !lock_st) begin
                    st_nxt  = ST_SAVE;
                    idx_nxt = '0;
                end
            end
            ST_SAVE: begin
                nv_req = 1'b1;
                nv_we  = 1'b1;
                if (nv_ack) begin
                    if (last) st_nxt = ST_IDLE;
                    else      idx_nxt = idx + 1'b1;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    assign busy     = (st != ST_IDLE);
    assign nv_addr  = idx;
    assign nv_wdata = save_data;
    assign ld_addr  = idx;
    assign ld_data  = nv_rdata & image_mask(idx);

endmodule

// File: rtl/cfgc_rdport.sv
module cfgc_rdport
    import cfgc_pkg::*;
#(
    parameter logic       DEV_TYPE  = 1'b1,
    parameter logic [2:0] REV_ID    = 3'd2,
    parameter logic [3:0] VENDOR_ID = 4'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] addr,
    input  logic [CFG_DW-1:0] live_byte,
    input  logic              busy,
    output logic [CFG_DW-1:0] rdata,
    output logic              rvalid,
    output logic              rej_flag
);

    logic [CFG_DW-1:0] val;

    always_comb begin
        if (addr == OFS_ID)
            val = {DEV_TYPE, REV_ID, VENDOR_ID};
        else if (addr == OFS_STAT)
            val = {7'b0, rej_flag};
        else if (addr == OFS_CTRL)
            val = (live_byte & 8'h3F) | (CFG_DW'(busy) << BUSY_BIT);
        else
            val = live_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata    <= '0;
            rvalid   <= 1'b0;
            rej_flag <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= val;
            if (wr_en && busy)
                rej_flag <= 1'b1;
            else if (rd_en && addr == OFS_STAT)
                rej_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/cfg_commit_ctrl.sv
module cfg_commit_ctrl
    import cfgc_pkg::*;
#(
    parameter int         NUM_BYTES = 80,
    parameter logic       DEV_TYPE  = 1'b1,
    parameter logic [2:0] REV_ID    = 3'd2,
    parameter logic [3:0] VENDOR_ID = 4'h1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [6:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        bus_rvalid,
    output logic        busy,
    output logic [6:0]  blk_cnt,
    output logic        pwr_down,
    output logic        nv_req,
    output logic        nv_we,
    output logic [6:0]  nv_addr,
    output logic [7:0]  nv_wdata,
    input  logic [7:0]  nv_rdata,
    input  logic        nv_ack
);

    logic              ld_we;
    logic [CFG_AW-1:0] ld_addr;
    logic [CFG_DW-1:0] ld_data;
    logic              rf_we;
    logic [CFG_AW-1:0] rf_waddr;
    logic [CFG_DW-1:0] rf_wdata;
    logic [CFG_DW-1:0] live_a, live_b, save_data;
    logic              trig_bit, trig_rise, lock_st, rej_flag;

    // Sequencer owns the write port while busy; bus writes are dropped then.
    assign rf_we     = busy ? ld_we   : bus_wr;
    assign rf_waddr  = busy ? ld_addr : bus_addr;
    assign rf_wdata  = busy ? ld_data : bus_wdata;
    assign save_data = live_b & image_mask(nv_addr);

    cfgc_regfile #(.NUM_BYTES(NUM_BYTES)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (rf_we),
        .waddr     (rf_waddr),
        .wdata     (rf_wdata),
        .raddr_a   (bus_addr),
        .rdata_a   (live_a),
        .raddr_b   (nv_addr),
        .rdata_b   (live_b),
        .pd_bit    (pwr_down),
        .trig_bit  (trig_bit),
        .cnt_field (blk_cnt)
    );

    cfgc_seq #(.NUM_BYTES(NUM_BYTES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_bit  (trig_bit),
        .save_data (save_data),
        .nv_req    (nv_req),
        .nv_we     (nv_we),
        .nv_addr   (nv_addr),
        .nv_wdata  (nv_wdata),
        .nv_rdata  (nv_rdata),
        .nv_ack    (nv_ack),
        .ld_we     (ld_we),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .busy      (busy),
        .trig_rise (trig_rise),
        .lock_st   (lock_st)
    );

    cfgc_rdport #(
        .DEV_TYPE  (DEV_TYPE),
        .REV_ID    (REV_ID),
        .VENDOR_ID (VENDOR_ID)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (bus_rd),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .live_byte (live_a),
        .busy      (busy),
        .rdata     (bus_rdata),
        .rvalid    (bus_rvalid),
        .rej_flag  (rej_flag)
    );

endmodule

// File: rtl/cfg_commit_chk.sv
module cfg_commit_chk
    import cfgc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       nv_req,
    input logic       nv_we,
    input logic [6:0] nv_addr,
    input logic [7:0] nv_wdata,
    input logic       bus_rd,
    input logic       bus_rvalid,
    input logic       bus_wr,
    input logic       trig_rise,
    input logic       lock_st,
    input logic       rej_flag
);

    // R6
    busy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req |-> busy);

    // R5
    start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(trig_rise));

    // R8
    img_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_req && nv_we && nv_addr == OFS_CTRL) |-> !nv_wdata[PD_BIT]);

    // R10
    img_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_req && nv_we && nv_addr == OFS_CNT) |-> !nv_wdata[TRIG_BIT]);

    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_st && !busy) |=> !busy);

    // R11
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    // R7
    wr_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr) |=> rej_flag);

endmodule

bind cfg_commit_ctrl cfg_commit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .nv_req     (nv_req),
    .nv_we      (nv_we),
    .nv_addr    (nv_addr),
    .nv_wdata   (nv_wdata),
    .bus_rd     (bus_rd),
    .bus_rvalid (bus_rvalid),
    .bus_wr     (bus_wr),
    .trig_rise  (trig_rise),
    .lock_st    (lock_st),
    .rej_flag   (rej_flag)
);

// File: tb/cfg_commit_ctrl_tb_top.sv
module cfg_commit_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 80;
    localparam int NVEC = 8;

    // {addr, write data, expected read-back}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h00, 8'hFF, 8'hA1},
        {8'h01, 8'hFF, 8'h3F},
        {8'h09, 8'hFF, 8'h00},
        {8'h07, 8'hFE, 8'h00},
        {8'h20, 8'h5A, 8'h5A},
        {8'h4F, 8'hC3, 8'hC3},
        {8'h50, 8'h77, 8'h00},
        {8'h06, 8'h40, 8'h40}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [6:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_rvalid, busy, pwr_down, nv_req, nv_we;
    logic [6:0] blk_cnt, nv_addr;
    logic [7:0] nv_wdata;
    logic [7:0] nv_rdata = '0;
    logic       nv_ack = 1'b0;

    logic [7:0] mem [NB];
    int         lat = 0;
    int         nv_wcount = 0;
    int         errs = 0, checks = 0, cyc = 0;
    string      vtag [NVEC] = '{"R2", "R3", "R3", "R3", "R11", "R11", "R3", "R4"};

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_commit_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .busy(busy), .blk_cnt(blk_cnt),
        .pwr_down(pwr_down), .nv_req(nv_req), .nv_we(nv_we),
        .nv_addr(nv_addr), .nv_wdata(nv_wdata), .nv_rdata(nv_rdata),
        .nv_ack(nv_ack)
    );

    // Storage stub: acknowledges each access after three cycles.
    always @(posedge clk) begin
        nv_ack <= 1'b0;
        if (nv_req && !nv_ack) begin
            if (lat == 2) begin
                lat    <= 0;
                nv_ack <= 1'b1;
                if (nv_we) begin
                    mem[nv_addr] <= nv_wdata;
                    nv_wcount    <= nv_wcount + 1;
                end else begin
                    nv_rdata <= mem[nv_addr];
                end
            end else begin
                lat <= lat + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R11 rvalid", 32'(bus_rvalid), 32'd1);
        d = bus_rdata;
    endtask

    task automatic wait_idle(input string req);
        int n;
        n = 0;
        while (busy && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(req, 32'(busy), 32'd0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errs++; checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int         wc;
        for (int i = 0; i < NB; i++) mem[i] = 8'((i * 7 + 3) & 8'hFF);
        mem[0] = 8'h00; mem[1] = 8'h03; mem[6] = 8'hA0; mem[7] = 8'h00;
        for (int i = 8; i < 16; i++) mem[i] = 8'h00;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R4: reset state
        check("R1 busy at reset", 32'(busy), 32'd1);
        check("R4 count reset", 32'(blk_cnt), 32'h50);

        // R7: reads served during the load
        bus_read(7'h00, rd);
        check("R7 read during load", 32'(rd), 32'hA1);
        bus_read(7'h01, rd);
        check("R6 busy bit during load", 32'(rd[6]), 32'd1);

        wait_idle("R1 load ends");
        bus_read(7'h30, rd);
        check("R1 loaded byte", 32'(rd), 32'h53);
        bus_read(7'h01, rd);
        check("R1 loaded ctrl", 32'(rd), 32'h03);
        check("R4 count after load", 32'(blk_cnt), 32'h50);

        // Table walk: write then read back
        for (int i = 0; i < NVEC; i++) begin
            bus_write(VEC[i][22:16], VEC[i][15:8]);
            bus_read(VEC[i][22:16], rd);
            check(vtag[i], 32'(rd), 32'(VEC[i][7:0]));
        end
        check("R4 count port", 32'(blk_cnt), 32'h20);

        // R8: power-down live
        bus_write(7'h01, 8'h10);
        check("R8 pwr_down live", 32'(pwr_down), 32'd1);
        bus_write(7'h30, 8'h99);

        // R5 / R6: commit on trigger edge
        wc = nv_wcount;
        bus_write(7'h06, 8'hA1);
        repeat (2) @(negedge clk);
        check("R5 commit started", 32'(busy), 32'd1);
        bus_read(7'h01, rd);
        check("R6 busy bit", 32'(rd[6]), 32'd1);
        bus_read(7'h30, rd);
        check("R7 read during commit", 32'(rd), 32'h99);
        bus_write(7'h30, 8'h11);
        wait_idle("R6 commit ends");
        check("R6 write count", 32'(nv_wcount - wc), 32'd80);
        check("R6 stored byte", 32'(mem[7'h30]), 32'h99);
        check("R8 stored pd", 32'(mem[1]), 32'h00);
        check("R10 stored trigger", 32'(mem[6]), 32'hA0);
        bus_read(7'h30, rd);
        check("R7 dropped write", 32'(rd), 32'h99);
        bus_read(7'h07, rd);
        check("R7 reject flag", 32'(rd), 32'h01);
        bus_read(7'h07, rd);
        check("R7 reject cleared", 32'(rd), 32'h00);

        // R5: holding high does not restart
        bus_write(7'h06, 8'hA1);
        repeat (4) @(negedge clk);
        check("R5 no restart", 32'(busy), 32'd0);

        // R9: live-only lock does not block
        bus_write(7'h06, 8'hA0);
        bus_write(7'h01, 8'h20);
        bus_write(7'h06, 8'hA1);
        repeat (2) @(negedge clk);
        check("R9 live lock commits", 32'(busy), 32'd1);
        wait_idle("R9 commit ends");
        check("R9 lock stored", 32'(mem[1]), 32'h20);

        // R9: stored lock blocks
        wc = nv_wcount;
        bus_write(7'h06, 8'hA0);
        bus_write(7'h06, 8'hA1);
        repeat (10) @(negedge clk);
        check("R9 locked no busy", 32'(busy), 32'd0);
        check("R9 locked no writes", 32'(nv_wcount - wc), 32'd0);
        bus_write(7'h30, 8'h44);
        bus_read(7'h30, rd);
        check("R9 live write while locked", 32'(rd), 32'h44);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule